// File: doc/BRIEF.md
# Stereo Digital Attenuator with Soft Mute

This block scales a stereo stream of signed 16-bit samples by a volume code of 8 bits per channel before the samples reach the digital-to-analog converter. Code zero gives +12 dB of gain, and each higher code adds 0.5 dB of attenuation down to -115 dB at code FEh. Code FFh is an exact mute. A link input lets the left code drive both channels. Each sample pair arrives with a one-cycle strobe, and the scaled pair leaves one clock later with its own valid pulse.

A soft-mute input walks the effective code of each channel one step at a time toward mute. One step is taken every sample or every fourth sample, so a full sweep lasts about 256 or 1024 sample periods. When soft mute drops, even partway through a sweep, the codes walk back the same way from wherever they stand to the programmed volume. Once both channels reach their targets, the block goes back to following the volume inputs directly. A busy output is high while a walk is still in progress.

Top module: `stereo_volume`

## Requirements
- R1: A code c below FFh scales a sample x to floor(x*M[r]*4 / 2^(q+15)), where q = c/12 and r = c mod 12. M[r] is 32768*10^(-r/40) rounded to the nearest integer: 32768, 30935, 29205, 27571, 26029, 24573, 23198, 21900, 20675, 19519, 18427, 17396. The result is saturated to the range -32768..32767.
- R2: A channel whose effective code is FFh outputs exactly zero.
- R3: With link high, the right channel uses vol_l and vol_r is ignored. With link low, each channel uses its own code.
- R4: When no soft-mute walk is in progress, a strobe applies the volume inputs present on that strobe's clock, with no walk.
- R5: While smute is high, each step raises the effective code of each channel by one until it reaches FFh. The code never decreases while smute is high.
- R6: Steps are paced by a strobe counter that starts at zero when the block is idle. With slow low, a step happens on every strobe, starting with the first strobe that sees smute. With slow high, a step happens on every fourth strobe, so the first step falls on the fourth strobe.
- R7: After smute falls, each step moves each channel's code one toward its programmed target, starting from its present value. The block goes back to following when both channels equal their targets on a strobe.
- R8: busy is high while returning. It is also high while muting as long as either code is still below FFh. Otherwise it is low.
- R9: After reset, out_l, out_r, out_vld and busy are low.
- R10: out_vld pulses exactly one clock after each smp_vld. out_l and out_r hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe, one cycle per stereo pair |
| smp_l | input | 16 | Left input sample, signed |
| smp_r | input | 16 | Right input sample, signed |
| vol_l | input | 8 | Left volume code (00h = +12 dB, FFh = mute) |
| vol_r | input | 8 | Right volume code |
| link | input | 1 | Left code controls both channels |
| smute | input | 1 | Soft-mute request |
| slow | input | 1 | Ramp pacing: 1 = step every 4 strobes, 0 = every strobe |
| out_vld | output | 1 | Output pair valid |
| out_l | output | 16 | Left output sample, signed |
| out_r | output | 16 | Right output sample, signed |
| busy | output | 1 | High while a mute or return walk is in progress |

## Verification
A wrong effective code shows up on the very next output pulse. The sample comes out scaled by a neighbouring gain, about 0.5 dB off for a code that is off by one, or it saturates near code zero. A mode error appears on busy right after the strobe that caused it, or as a jump larger than one step. An error in the pacing counter moves each step by one or more strobes, and this is visible in the first few samples after smute changes. The bench predicts every strobe's outputs from a strobe-level model of the stepping rules. It sweeps all 256 codes against extreme and ordinary samples.

// File: rtl/vol_pkg.sv
package vol_pkg;

    localparam int FRAC_W   = 15;             // mantissa fraction bits
    localparam int MANT_W   = FRAC_W + 1;     // unsigned mantissa width
    localparam int BOOST_SH = 2;              // +12 dB headroom as a left shift
    localparam int OCT_STEPS = 12;            // 0.5 dB codes per halving

    typedef enum logic [1:0] {
        MODE_FOLLOW = 2'd0,
        MODE_MUTING = 2'd1,
        MODE_RETURN = 2'd2
    } mode_e;

    // 2^FRAC_W * 10^(-r/40), rounded, for r within one halving
    function automatic logic [MANT_W-1:0] vol_mant(input logic [3:0] r);
        case (r)
            4'd0:    vol_mant = 16'd32768;
            4'd1:    vol_mant = 16'd30935;
            4'd2:    vol_mant = 16'd29205;
            4'd3:    vol_mant = 16'd27571;
            4'd4:    vol_mant = 16'd26029;
            4'd5:    vol_mant = 16'd24573;
            4'd6:    vol_mant = 16'd23198;
            4'd7:    vol_mant = 16'd21900;
            4'd8:    vol_mant = 16'd20675;
            4'd9:    vol_mant = 16'd19519;
            4'd10:   vol_mant = 16'd18427;
            default: vol_mant = 16'd17396;
        endcase
    endfunction

endpackage

// File: rtl/vol_gain.sv
module vol_gain
    import vol_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CODE_W = 8
) (
    input  logic        [CODE_W-1:0] code,
    input  logic signed [DATA_W-1:0] x,
    output logic signed [DATA_W-1:0] y
);

    localparam int PROD_W = DATA_W + MANT_W + 1;
    localparam logic [CODE_W-1:0] MUTE_CODE = '1;
    localparam logic signed [PROD_W-1:0] MAX_V = PROD_W'((64'sd1 <<< (DATA_W-1)) - 64'sd1);
    localparam logic signed [PROD_W-1:0] MIN_V = ~MAX_V;

    logic        [CODE_W-1:0] oct;
    logic        [CODE_W-1:0] rem;
    logic        [MANT_W-1:0] mant;
    logic        [CODE_W:0]   sh;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;

    always_comb begin
        oct    = code / CODE_W'(OCT_STEPS);
        rem    = code % CODE_W'(OCT_STEPS);
        mant   = vol_mant(rem[3:0]);
        sh     = {1'b0, oct} + (CODE_W+1)'(FRAC_W - BOOST_SH);
        prod   = PROD_W'(x) * PROD_W'($signed({1'b0, mant}));
        scaled = prod >>> sh;
        if (code == MUTE_CODE) begin
            y = '0;
        end else if (scaled > MAX_V) begin
            y = MAX_V[DATA_W-1:0];
        end else if (scaled < MIN_V) begin
            y = MIN_V[DATA_W-1:0];
        end else begin
            y = scaled[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/vol_ramp.sv
module vol_ramp
    import vol_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int SLOW_DIV = 4,
    parameter int FAST_DIV = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              smute,
    input  logic              slow,
    input  logic              link,
    input  logic [CODE_W-1:0] vol_l,
    input  logic [CODE_W-1:0] vol_r,
    output logic [CODE_W-1:0] nxt_l,
    output logic [CODE_W-1:0] nxt_r,
    output logic [CODE_W-1:0] cur_l,
    output logic [CODE_W-1:0] cur_r,
    output logic              busy
);

    localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int CNT_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;
    localparam logic [CODE_W-1:0] MUTE_CODE = '1;

    typedef struct packed {
        mode_e             mode;
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] cur_l;
        logic [CODE_W-1:0] cur_r;
    } ramp_t;

    ramp_t s_d, s_q;
    logic [CODE_W-1:0] tgt_l, tgt_r;
    logic              active, tick;

    function automatic logic [CODE_W-1:0] toward(input logic [CODE_W-1:0] c,
                                                 input logic [CODE_W-1:0] t);
        if (c < t)      toward = c + 1'b1;
        else if (c > t) toward = c - 1'b1;
        else            toward = c;
    endfunction

    always_comb begin
        s_d    = s_q;
        tgt_l  = vol_l;
        tgt_r  = link ? vol_l : vol_r;
        active = smute || (s_q.mode != MODE_FOLLOW);
        tick   = active && (s_q.cnt == (slow ? CNT_W'(SLOW_DIV-1) : CNT_W'(FAST_DIV-1)));
        if (stb) begin
            if (smute) begin
                s_d.mode = MODE_MUTING;
                if (tick) begin
                    s_d.cur_l = toward(s_q.cur_l, MUTE_CODE);
                    s_d.cur_r = toward(s_q.cur_r, MUTE_CODE);
                end
            end else if (s_q.mode != MODE_FOLLOW) begin
                if (tick) begin
                    s_d.cur_l = toward(s_q.cur_l, tgt_l);
                    s_d.cur_r = toward(s_q.cur_r, tgt_r);
                end
                s_d.mode = ((s_d.cur_l == tgt_l) && (s_d.cur_r == tgt_r)) ?
                           MODE_FOLLOW : MODE_RETURN;
            end else begin
                s_d.cur_l = tgt_l;
                s_d.cur_r = tgt_r;
            end
            if (s_d.mode == MODE_FOLLOW) s_d.cnt = '0;
            else                         s_d.cnt = tick ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mode  <= MODE_FOLLOW;
            s_q.cnt   <= '0;
            s_q.cur_l <= MUTE_CODE;
            s_q.cur_r <= MUTE_CODE;
        end else begin
            s_q <= s_d;
        end
    end

    assign nxt_l = s_d.cur_l;
    assign nxt_r = s_d.cur_r;
    assign cur_l = s_q.cur_l;
    assign cur_r = s_q.cur_r;
    assign busy  = (s_q.mode == MODE_RETURN) ||
                   ((s_q.mode == MODE_MUTING) &&
                    !((s_q.cur_l == MUTE_CODE) && (s_q.cur_r == MUTE_CODE)));

    p_climb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && smute) |=> (s_q.cur_l >= $past(s_q.cur_l)) && (s_q.cur_r >= $past(s_q.cur_r)));

    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && s_q.mode != MODE_FOLLOW) |=>
            ((s_q.cur_l == $past(s_q.cur_l)) || (s_q.cur_l == $past(s_q.cur_l) + 1'b1) ||
             (s_q.cur_l == $past(s_q.cur_l) - 1'b1)));

    p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !smute && s_q.mode == MODE_FOLLOW) |=> (s_q.cur_l == $past(vol_l)));

    p_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !smute && link && s_q.mode == MODE_FOLLOW) |=> (s_q.cur_r == $past(vol_l)));

endmodule

// File: rtl/stereo_volume.sv
module stereo_volume
    import vol_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CODE_W   = 8,
    parameter int SLOW_DIV = 4,
    parameter int FAST_DIV = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_vld,
    input  logic signed [DATA_W-1:0] smp_l,
    input  logic signed [DATA_W-1:0] smp_r,
    input  logic        [CODE_W-1:0] vol_l,
    input  logic        [CODE_W-1:0] vol_r,
    input  logic                     link,
    input  logic                     smute,
    input  logic                     slow,
    output logic                     out_vld,
    output logic signed [DATA_W-1:0] out_l,
    output logic signed [DATA_W-1:0] out_r,
    output logic                     busy
);

    localparam int NCH = 2;
    localparam logic [CODE_W-1:0] MUTE_CODE = '1;

    typedef struct packed {
        logic                     vld;
        logic signed [DATA_W-1:0] l;
        logic signed [DATA_W-1:0] r;
    } out_t;

    out_t o_d, o_q;
    logic        [CODE_W-1:0] code_a [NCH];
    logic signed [DATA_W-1:0] x_a    [NCH];
    logic signed [DATA_W-1:0] y_a    [NCH];
    logic        [CODE_W-1:0] cur_l_q, cur_r_q;

    vol_ramp #(
        .CODE_W  (CODE_W),
        .SLOW_DIV(SLOW_DIV),
        .FAST_DIV(FAST_DIV)
    ) u_ramp (
        .clk  (clk),
        .rst_n(rst_n),
        .stb  (smp_vld),
        .smute(smute),
        .slow (slow),
        .link (link),
        .vol_l(vol_l),
        .vol_r(vol_r),
        .nxt_l(code_a[0]),
        .nxt_r(code_a[1]),
        .cur_l(cur_l_q),
        .cur_r(cur_r_q),
        .busy (busy)
    );

    assign x_a[0] = smp_l;
    assign x_a[1] = smp_r;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        vol_gain #(
            .DATA_W(DATA_W),
            .CODE_W(CODE_W)
        ) u_gain (
            .code(code_a[ch]),
            .x   (x_a[ch]),
            .y   (y_a[ch])
        );
    end

    always_comb begin
        o_d     = o_q;
        o_d.vld = smp_vld;
        if (smp_vld) begin
            o_d.l = y_a[0];
            o_d.r = y_a[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_vld = o_q.vld;
    assign out_l   = o_q.l;
    assign out_r   = o_q.r;

    p_mute_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (o_q.vld && cur_l_q == MUTE_CODE) |-> (o_q.l == '0));

    p_vld_r10: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> out_vld);

    p_vld_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> (!out_vld && $stable(out_l) && $stable(out_r)));

endmodule

// File: tb/stereo_volume_tb.sv
module stereo_volume_tb;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_vld = 1'b0;
    logic signed [15:0] smp_l = '0, smp_r = '0;
    logic        [7:0] vol_l = '0, vol_r = '0;
    logic              link = 1'b0, smute = 1'b0, slow = 1'b0;
    logic              out_vld, busy;
    logic signed [15:0] out_l, out_r;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // strobe-level reference model state
    int         m_mode = 0;          // 0 follow, 1 muting, 2 returning
    logic [1:0] m_cnt  = '0;
    int         m_l = 255, m_r = 255;
    int         exp_l = 0, exp_r = 0;
    int         smp_idx = 0;

    always #5 clk = ~clk;

    stereo_volume u_dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_l(smp_l), .smp_r(smp_r),
        .vol_l(vol_l), .vol_r(vol_r), .link(link), .smute(smute), .slow(slow),
        .out_vld(out_vld), .out_l(out_l), .out_r(out_r), .busy(busy)
    );

    function automatic int gain_of(input int x, input int code);
        int     q;
        int     r;
        real    mr;
        longint m;
        longint p;
        longint y;
        if (code == 255) return 0;
        q  = code / 12;
        r  = code % 12;
        mr = 32768.0 * (10.0 ** (-r / 40.0));
        m  = longint'($rtoi(mr + 0.5));
        p  = longint'(x) * m * 4;
        y  = p >>> (q + 15);
        if (y > 32767)  y = 32767;
        if (y < -32768) y = -32768;
        return int'(y);
    endfunction

    function automatic int step_to(input int c, input int t);
        if (c < t) return c + 1;
        if (c > t) return c - 1;
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic strobe(input int xl, input int xr, input string tag);
        int  tl, tr, div;
        bit  tick, exp_busy;
        @(negedge clk);
        check(out_vld == 1'b0, "R10", "out_vld between strobes", int'(out_vld), 0);
        smp_vld = 1'b1;
        smp_l   = 16'(xl);
        smp_r   = 16'(xr);
        tl   = int'(vol_l);
        tr   = link ? int'(vol_l) : int'(vol_r);
        div  = slow ? 4 : 1;
        tick = (smute || m_mode != 0) && (int'(m_cnt) == div - 1);
        if (smute) begin
            m_mode = 1;
            if (tick) begin m_l = step_to(m_l, 255); m_r = step_to(m_r, 255); end
        end else if (m_mode != 0) begin
            if (tick) begin m_l = step_to(m_l, tl); m_r = step_to(m_r, tr); end
            m_mode = (m_l == tl && m_r == tr) ? 0 : 2;
        end else begin
            m_l = tl;
            m_r = tr;
        end
        if (m_mode == 0) m_cnt = '0;
        else             m_cnt = tick ? 2'd0 : m_cnt + 2'd1;
        exp_l    = gain_of(xl, m_l);
        exp_r    = gain_of(xr, m_r);
        exp_busy = (m_mode == 2) || (m_mode == 1 && !(m_l == 255 && m_r == 255));
        @(negedge clk);
        smp_vld = 1'b0;
        check(out_vld == 1'b1, tag, "out_vld", int'(out_vld), 1);
        check(int'(out_l) == exp_l, tag, "out_l", int'(out_l), exp_l);
        check(int'(out_r) == exp_r, tag, "out_r", int'(out_r), exp_r);
        check(busy == exp_busy, tag, "busy", int'(busy), int'(exp_busy));
    endtask

    function automatic int pattern(input int i);
        return ((i * 2731 + 977) % 65536) - 32768;
    endfunction

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            smp_idx++;
            strobe(pattern(smp_idx), pattern(smp_idx * 7 + 3), tag);
        end
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(out_l == 16'sd0, "R9", "out_l", int'(out_l), 0);
        check(out_r == 16'sd0, "R9", "out_r", int'(out_r), 0);
        check(out_vld == 1'b0, "R9", "out_vld", int'(out_vld), 0);
        check(busy == 1'b0, "R9", "busy", int'(busy), 0);

        // R1 R2: every code against extreme and ordinary samples
        for (int c = 0; c < 256; c++) begin
            vol_l = 8'(c);
            vol_r = 8'(255 - c);
            strobe(32767, -32768, "R1 R2");
            strobe(-32768, 32767, "R1 R2");
            strobe(1000, -1, "R1 R2");
            strobe(-1, 12345, "R1 R2");
            strobe(pattern(c), pattern(c + 99), "R1 R2");
        end

        // R3: linked and independent
        link = 1'b1; vol_l = 8'd20; vol_r = 8'd200;
        run(4, "R3");
        link = 1'b0;
        run(2, "R3");

        // R4: immediate updates when idle, including through R10 hold
        vol_l = 8'd3; vol_r = 8'd90;
        run(1, "R4");
        vol_l = 8'd150; vol_r = 8'd0;
        run(1, "R4");
        repeat (3) @(negedge clk);
        check(int'(out_l) == exp_l, "R10", "hold out_l", int'(out_l), exp_l);

        // R5 R6 R8: fast mute, partial, then release mid-walk (R7)
        slow = 1'b0; vol_l = 8'd10; vol_r = 8'd40;
        run(2, "R4");
        smute = 1'b1;
        run(150, "R5 R6 R8");
        smute = 1'b0;
        run(200, "R7 R8");
        // full mute to FFh and hold, then release with a target change
        smute = 1'b1;
        run(300, "R5 R2 R8");
        smute = 1'b0;
        run(20, "R7");
        vol_l = 8'd60;
        run(260, "R7 R8");

        // R6: slow pacing, linked, released mid-walk
        slow = 1'b1; link = 1'b1; vol_l = 8'd30;
        run(2, "R3");
        smute = 1'b1;
        run(301, "R6 R5");
        smute = 1'b0;
        run(400, "R6 R7");
        link = 1'b0; vol_r = 8'd7;
        run(3, "R4");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule